// File: doc/BRIEF.md
# Rising-Edge Delay Search Controller

This block places a per-lane strobe delay on the rising edge of a sampled signal. A search is started with a base delay for every lane. The block first takes three coarse probes, spaced a fixed number of delay steps apart. From the three results it chooses a start delay and a search direction for each lane. It then walks all lanes in parallel, one delay unit per sample, until a sample arrives in which no lane needs to move.

Every sample comes from an external sampler through a request/acknowledge handshake. The block presents the delays, raises a request, and reads one majority-voted bit per lane in the acknowledge cycle. A normal finish pulses a precharge-all request together with the completion pulse. Two faults stop the search early. One is a lane that keeps moving past an iteration limit. The other is a backward lane that would step below zero.

Top module: `edge_seek_ctrl`

## Requirements
- R1: A one-cycle `start_i` while idle captures `base_dly_i`, puts the base delays on `dly_o` and raises `busy_o` on the next cycle. `start_i` while busy is ignored and does not change the result.
- R2: `smp_req_o` rises only in a cycle after the delays for that sample are already on `dly_o`. It stays high until a cycle with `smp_ack_i` high. It is low in the cycle after that acknowledge. The lane bits are taken from `smp_bits_i` in the acknowledge cycle, with lane i at bit i.
- R3: The three probes are taken at base, base+PROBE_STEP and base+2*PROBE_STEP (default 26), in that order. Each lane's pattern holds the first probe's bit in its most significant position.
- R4: The start point depends on the pattern. For 000 or 100 the lane starts at base+2*PROBE_STEP and searches forward. For 001 or 101 it starts at base+PROBE_STEP and searches forward. For 010 or 011 it starts at base and searches forward. For 110 or 111 it starts at base and searches backward.
- R5: In the step phase, a forward lane that samples 0 moves up by 1, and a backward lane that samples 1 moves down by 1. Any other lane keeps its delay for that sample.
- R6: A step sample in which no lane moves ends the search. `done_o` and `pre_req_o` pulse together for one cycle, and `dly_o` holds the final delays.
- R7: If the ITER_LIMIT-th step sample still moves a lane, those moves are applied. `err_timeout_o` is then set, `done_o` pulses and `pre_req_o` stays low.
- R8: If a backward lane at delay 0 samples 1, `err_underflow_o` is set and no lane's delay changes for that sample. `done_o` pulses and `pre_req_o` stays low. The two error flags are never both set.
- R9: After reset, every output is 0. The error flags hold until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a search (honoured only while idle) |
| base_dly_i | input | NUM_LANES*DLY_W | Base delay per lane, lane i at bits [i*DLY_W +: DLY_W] |
| smp_ack_i | input | 1 | Sampler acknowledge; lane bits valid in this cycle |
| smp_bits_i | input | NUM_LANES | Majority-voted sample per lane |
| dly_o | output | NUM_LANES*DLY_W | Delay currently programmed per lane |
| smp_req_o | output | 1 | Request for one sample at the presented delays |
| pre_req_o | output | 1 | Precharge-all request, one cycle, on normal finish |
| done_o | output | 1 | One-cycle end-of-search pulse |
| busy_o | output | 1 | Search in progress |
| err_timeout_o | output | 1 | Iteration limit exceeded |
| err_underflow_o | output | 1 | Backward step below zero attempted |

## Verification
Two events can fall on the same step sample. The first is convergence against the iteration limit. Two runs share one lane model and differ by a single step. In one the last lane settles exactly on the ITER_LIMIT-th sample, which must give a clean finish with precharge. In the other that sample still moves the lane, which must give a timeout with the move applied. The second collision is an underflow on one lane while other lanes want to move forward in that same sample. It is judged by checking that every lane keeps its pre-sample delay and that no precharge is raised.

// File: rtl/edge_seek_pkg.sv
package edge_seek_pkg;

    // Search phases of the controller.
    typedef enum logic [1:0] {
        SEEK_IDLE  = 2'd0,
        SEEK_PROBE = 2'd1,
        SEEK_STEP  = 2'd2
    } seek_state_e;

    // Three coarse probes make a three-bit pattern per lane.
    localparam int unsigned PAT_W  = 3;
    // Only the first two probe results need storage; the third arrives live.
    localparam int unsigned HIST_W = PAT_W - 1;

endpackage

// File: rtl/edge_seek_classify.sv
module edge_seek_classify #(
    parameter int unsigned DLY_W      = 10,
    parameter int unsigned PROBE_STEP = 26
) (
    input  logic [edge_seek_pkg::PAT_W-1:0] pat_i,
    input  logic [DLY_W-1:0]                base_i,
    output logic [DLY_W-1:0]                start_o,
    output logic                            backward_o
);
    localparam logic [DLY_W-1:0] OFS_ONE = DLY_W'(PROBE_STEP);
    localparam logic [DLY_W-1:0] OFS_TWO = DLY_W'(2 * PROBE_STEP);

    // MSB is the first probe. Low-at-the-end patterns are still before
    // the edge, so the search starts from the last low probe and goes up.
    always_comb begin
        start_o    = base_i;
        backward_o = 1'b0;
        case (pat_i)
            3'b000, 3'b100: start_o = base_i + OFS_TWO;
            3'b001, 3'b101: start_o = base_i + OFS_ONE;
            3'b010, 3'b011: start_o = base_i;
            default: begin
                start_o    = base_i;
                backward_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/edge_seek_lane_step.sv
module edge_seek_lane_step #(
    parameter int unsigned DLY_W = 10
) (
    input  logic             en_i,
    input  logic             backward_i,
    input  logic             bit_i,
    input  logic [DLY_W-1:0] dly_i,
    output logic             moved_o,
    output logic             uflow_o,
    output logic [DLY_W-1:0] dly_next_o
);
    // A lane keeps walking while it still sees the level before the edge.
    always_comb begin
        moved_o    = en_i & (backward_i ? bit_i : ~bit_i);
        uflow_o    = moved_o & backward_i & (dly_i == '0);
        dly_next_o = dly_i;
        if (moved_o && !uflow_o) begin
            dly_next_o = backward_i ? (dly_i - 1'b1) : (dly_i + 1'b1);
        end
    end
endmodule

// File: rtl/edge_seek_iter_guard.sv
module edge_seek_iter_guard #(
    parameter int unsigned ITER_LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic last_o
);
    localparam int unsigned CNT_W = $clog2(ITER_LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(ITER_LIMIT - 1);
    localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(ITER_LIMIT);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (tick_i && cnt_q != MAX_CNT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // High when the current step sample is the ITER_LIMIT-th one.
    assign last_o = tick_i & (cnt_q == LAST_CNT);

    // R7: the step counter never runs beyond the limit.
    assert_iter_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= MAX_CNT);
endmodule

// File: rtl/edge_seek_ctrl.sv
module edge_seek_ctrl #(
    parameter int unsigned NUM_LANES  = 4,
    parameter int unsigned DLY_W      = 10,
    parameter int unsigned PROBE_STEP = 26,
    parameter int unsigned ITER_LIMIT = 256
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [NUM_LANES*DLY_W-1:0] base_dly_i,
    input  logic                       smp_ack_i,
    input  logic [NUM_LANES-1:0]       smp_bits_i,
    output logic [NUM_LANES*DLY_W-1:0] dly_o,
    output logic                       smp_req_o,
    output logic                       pre_req_o,
    output logic                       done_o,
    output logic                       busy_o,
    output logic                       err_timeout_o,
    output logic                       err_underflow_o
);
    import edge_seek_pkg::*;

    localparam logic [DLY_W-1:0] OFS_ONE    = DLY_W'(PROBE_STEP);
    localparam logic [DLY_W-1:0] OFS_TWO    = DLY_W'(2 * PROBE_STEP);
    localparam logic [1:0]       LAST_PROBE = 2'd2;

    typedef struct packed {
        seek_state_e                                st;
        logic [1:0]                                 probe;
        logic [NUM_LANES-1:0][DLY_W-1:0]            base;
        logic [NUM_LANES-1:0][DLY_W-1:0]            dly;
        logic [NUM_LANES-1:0][HIST_W-1:0]           hist;
        logic [NUM_LANES-1:0]                       back;
        logic                                       req;
        logic                                       pre;
        logic                                       done;
        logic                                       err_to;
        logic                                       err_uf;
    } seek_regs_t;

    seek_regs_t r_d, r_q;

    logic                              accept;
    logic                              step_ack;
    logic                              iter_last;
    logic [NUM_LANES-1:0][PAT_W-1:0]   pat_full;
    logic [NUM_LANES-1:0][DLY_W-1:0]   start_dly;
    logic [NUM_LANES-1:0]              start_back;
    logic [NUM_LANES-1:0][DLY_W-1:0]   step_dly;
    logic [NUM_LANES-1:0]              moved;
    logic [NUM_LANES-1:0]              uflow;
    logic [DLY_W-1:0]                  probe_ofs;

    assign accept    = (r_q.st == SEEK_IDLE) && start_i;
    assign step_ack  = (r_q.st == SEEK_STEP) && r_q.req && smp_ack_i;
    assign probe_ofs = (r_q.probe == 2'd0) ? OFS_ONE : OFS_TWO;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        // Third probe bit is used live in its acknowledge cycle.
        assign pat_full[l] = {r_q.hist[l], smp_bits_i[l]};

        edge_seek_classify #(
            .DLY_W      (DLY_W),
            .PROBE_STEP (PROBE_STEP)
        ) u_classify (
            .pat_i      (pat_full[l]),
            .base_i     (r_q.base[l]),
            .start_o    (start_dly[l]),
            .backward_o (start_back[l])
        );

        edge_seek_lane_step #(
            .DLY_W (DLY_W)
        ) u_step (
            .en_i       (step_ack),
            .backward_i (r_q.back[l]),
            .bit_i      (smp_bits_i[l]),
            .dly_i      (r_q.dly[l]),
            .moved_o    (moved[l]),
            .uflow_o    (uflow[l]),
            .dly_next_o (step_dly[l])
        );
    end

    edge_seek_iter_guard #(
        .ITER_LIMIT (ITER_LIMIT)
    ) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .tick_i  (step_ack),
        .last_o  (iter_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.pre  = 1'b0;
        r_d.done = 1'b0;
        case (r_q.st)
            SEEK_IDLE: begin
                if (start_i) begin
                    r_d.st     = SEEK_PROBE;
                    r_d.probe  = 2'd0;
                    r_d.base   = base_dly_i;
                    r_d.dly    = base_dly_i;
                    r_d.hist   = '0;
                    r_d.back   = '0;
                    r_d.req    = 1'b0;
                    r_d.err_to = 1'b0;
                    r_d.err_uf = 1'b0;
                end
            end
            SEEK_PROBE: begin
                if (!r_q.req) begin
                    r_d.req = 1'b1;
                end else if (smp_ack_i) begin
                    r_d.req = 1'b0;
                    if (r_q.probe == LAST_PROBE) begin
                        r_d.dly  = start_dly;
                        r_d.back = start_back;
                        r_d.st   = SEEK_STEP;
                    end else begin
                        for (int l = 0; l < NUM_LANES; l++) begin
                            r_d.hist[l][~r_q.probe[0]] = smp_bits_i[l];
                            r_d.dly[l] = r_q.base[l] + probe_ofs;
                        end
                        r_d.probe = r_q.probe + 2'd1;
                    end
                end
            end
            SEEK_STEP: begin
                if (!r_q.req) begin
                    r_d.req = 1'b1;
                end else if (smp_ack_i) begin
                    r_d.req = 1'b0;
                    if (|uflow) begin
                        r_d.err_uf = 1'b1;
                        r_d.done   = 1'b1;
                        r_d.st     = SEEK_IDLE;
                    end else begin
                        r_d.dly = step_dly;
                        if (!(|moved)) begin
                            r_d.pre  = 1'b1;
                            r_d.done = 1'b1;
                            r_d.st   = SEEK_IDLE;
                        end else if (iter_last) begin
                            r_d.err_to = 1'b1;
                            r_d.done   = 1'b1;
                            r_d.st     = SEEK_IDLE;
                        end
                    end
                end
            end
            default: begin
                r_d.st  = SEEK_IDLE;
                r_d.req = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= SEEK_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign dly_o           = r_q.dly;
    assign smp_req_o       = r_q.req;
    assign pre_req_o       = r_q.pre;
    assign done_o          = r_q.done;
    assign busy_o          = (r_q.st != SEEK_IDLE);
    assign err_timeout_o   = r_q.err_to;
    assign err_underflow_o = r_q.err_uf;

    // R2: a consumed request is withdrawn on the next cycle.
    assert_req_withdrawn_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_req_o && smp_ack_i) |=> !smp_req_o);

    // R2: delays are already settled when a request rises.
    assert_dly_before_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smp_req_o) |-> $stable(dly_o));

    // R2: requests only exist during a search.
    assert_req_in_search_R2: assert property (@(posedge clk) disable iff (!rst_n)
        smp_req_o |-> busy_o);

    // R6: completion is a single-cycle pulse.
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: precharge accompanies only a clean finish.
    assert_pre_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pre_req_o |-> (done_o && !err_timeout_o && !err_underflow_o));

    // R8: the two faults exclude each other.
    assert_err_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_timeout_o && err_underflow_o));

    // R8: an underflowing sample leaves every delay untouched.
    assert_uflow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ack && (|uflow)) |=> $stable(dly_o));

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_chk
        // R5: one step sample moves a lane by at most one unit.
        assert_unit_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
            step_ack |=> (r_q.dly[l] == $past(r_q.dly[l]))
                      || (r_q.dly[l] == $past(r_q.dly[l]) + 1'b1)
                      || (r_q.dly[l] == $past(r_q.dly[l]) - 1'b1));
    end
endmodule

// File: tb/edge_seek_ctrl_bench.sv
module edge_seek_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NL   = 4;
    localparam int DW   = 10;
    localparam int STEP = 26;
    localparam int LIM  = 40;
    localparam int VW   = NL * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [VW-1:0] base_dly_i = '0;
    logic          smp_ack_i = 1'b0;
    logic [NL-1:0] smp_bits_i = '0;
    logic [VW-1:0] dly_o;
    logic          smp_req_o, pre_req_o, done_o, busy_o;
    logic          err_timeout_o, err_underflow_o;

    edge_seek_ctrl #(
        .NUM_LANES  (NL),
        .DLY_W      (DW),
        .PROBE_STEP (STEP),
        .ITER_LIMIT (LIM)
    ) u_edge_seek_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .base_dly_i      (base_dly_i),
        .smp_ack_i       (smp_ack_i),
        .smp_bits_i      (smp_bits_i),
        .dly_o           (dly_o),
        .smp_req_o       (smp_req_o),
        .pre_req_o       (pre_req_o),
        .done_o          (done_o),
        .busy_o          (busy_o),
        .err_timeout_o   (err_timeout_o),
        .err_underflow_o (err_underflow_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Per-lane signal model: force 1 = always high, 2 = always low,
    // else high when (d + ph) mod per >= lo.
    int m_per[NL];
    int m_lo[NL];
    int m_ph[NL];
    int m_force[NL];
    int smp_lat = 0;

    typedef struct {
        logic [VW-1:0] vec;
        string         tag;
    } smp_t;

    typedef struct {
        logic [VW-1:0] vec;
        bit            pre;
        bit            to;
        bit            uf;
    } res_t;

    smp_t smp_q[$];
    res_t res_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit model_bit(input int l, input int d);
        if (m_force[l] == 1) return 1'b1;
        if (m_force[l] == 2) return 1'b0;
        return ((d + m_ph[l]) % m_per[l]) >= m_lo[l];
    endfunction

    function automatic logic [VW-1:0] pack(input int d[NL]);
        logic [VW-1:0] v;
        for (int l = 0; l < NL; l++) v[l*DW +: DW] = DW'(d[l]);
        return v;
    endfunction

    function automatic logic [VW-1:0] mk_base(input int b);
        int d[NL];
        for (int l = 0; l < NL; l++) d[l] = b;
        return pack(d);
    endfunction

    // Driver side of the scoreboard: derive every expected sample point and
    // the final result from the requirements, then queue them.
    task automatic ref_push(input logic [VW-1:0] base);
        int  b[NL];
        int  d[NL];
        int  pat[NL];
        bit  back[NL];
        int  iter;
        bit  stop;
        bit  moved;
        bit  uf;
        bit  bits[NL];
        res_t r;
        for (int l = 0; l < NL; l++) begin
            b[l]   = int'(base[l*DW +: DW]);
            pat[l] = 0;
        end
        // R3: three probes, first result in the MSB.
        for (int k = 0; k < 3; k++) begin
            for (int l = 0; l < NL; l++) begin
                d[l]   = b[l] + k * STEP;
                pat[l] = (pat[l] << 1) | int'(model_bit(l, d[l]));
            end
            smp_q.push_back('{pack(d), "R3"});
        end
        // R4: start point and direction.
        for (int l = 0; l < NL; l++) begin
            back[l] = 1'b0;
            case (pat[l])
                0, 4: d[l] = b[l] + 2 * STEP;
                1, 5: d[l] = b[l] + STEP;
                2, 3: d[l] = b[l];
                default: begin d[l] = b[l]; back[l] = 1'b1; end
            endcase
        end
        iter = 0;
        stop = 1'b0;
        r.pre = 1'b0; r.to = 1'b0; r.uf = 1'b0;
        while (!stop) begin
            smp_q.push_back('{pack(d), (iter == 0) ? "R4" : "R5"});
            iter++;
            moved = 1'b0;
            uf = 1'b0;
            for (int l = 0; l < NL; l++) begin
                bits[l] = model_bit(l, d[l]);
                if (back[l] ? bits[l] : !bits[l]) begin
                    moved = 1'b1;
                    if (back[l] && d[l] == 0) uf = 1'b1;
                end
            end
            if (uf) begin
                r.uf = 1'b1;
                stop = 1'b1;
            end else begin
                for (int l = 0; l < NL; l++) begin
                    if (back[l] && bits[l]) d[l] = d[l] - 1;
                    if (!back[l] && !bits[l]) d[l] = d[l] + 1;
                end
                if (!moved) begin
                    r.pre = 1'b1;
                    stop = 1'b1;
                end else if (iter == LIM) begin
                    r.to = 1'b1;
                    stop = 1'b1;
                end
            end
        end
        r.vec = pack(d);
        res_q.push_back(r);
    endtask

    // Sampler model and monitor side of the scoreboard, all at the negedge.
    initial begin : sampler_monitor
        logic [VW-1:0] prev_dly;
        bit            prev_req;
        int            lat_cnt;
        smp_t          es;
        res_t          er;
        prev_dly = '0;
        prev_req = 1'b0;
        lat_cnt  = 0;
        forever begin
            @(negedge clk);
            if (done_o) begin
                if (res_q.size() == 0) begin
                    chk(1'b0, "R6", "unexpected done", 64'(1), 64'(0));
                end else begin
                    er = res_q.pop_front();
                    chk(dly_o == er.vec, er.to ? "R7" : (er.uf ? "R8" : "R6"),
                        "final delays", 64'(dly_o), 64'(er.vec));
                    chk(pre_req_o == er.pre, "R6", "precharge request",
                        64'(pre_req_o), 64'(er.pre));
                    chk(err_timeout_o == er.to, "R7", "timeout flag",
                        64'(err_timeout_o), 64'(er.to));
                    chk(err_underflow_o == er.uf, "R8", "underflow flag",
                        64'(err_underflow_o), 64'(er.uf));
                end
            end
            if (smp_ack_i) begin
                smp_ack_i = 1'b0;
                chk(!smp_req_o, "R2", "request low after acknowledge",
                    64'(smp_req_o), 64'(0));
            end else if (smp_req_o) begin
                if (!prev_req) begin
                    chk(dly_o == prev_dly, "R2", "delays settled before request",
                        64'(dly_o), 64'(prev_dly));
                end
                if (lat_cnt >= smp_lat) begin
                    lat_cnt = 0;
                    if (smp_q.size() == 0) begin
                        chk(1'b0, "R2", "unexpected sample request", 64'(1), 64'(0));
                    end else begin
                        es = smp_q.pop_front();
                        chk(dly_o == es.vec, es.tag, "sample delays",
                            64'(dly_o), 64'(es.vec));
                    end
                    for (int l = 0; l < NL; l++) begin
                        smp_bits_i[l] = model_bit(l, int'(dly_o[l*DW +: DW]));
                    end
                    smp_ack_i = 1'b1;
                end else begin
                    lat_cnt++;
                end
            end
            prev_req = smp_req_o;
            prev_dly = dly_o;
        end
    end

    task automatic set_lane(input int l, input int per, input int lo,
                            input int ph, input int frc);
        m_per[l] = per; m_lo[l] = lo; m_ph[l] = ph; m_force[l] = frc;
    endtask

    task automatic run_case(input logic [VW-1:0] base, input int lat,
                            input bit pulse_again);
        ref_push(base);
        smp_lat    = lat;
        base_dly_i = base;
        start_i    = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R1", "busy after start", 64'(busy_o), 64'(1));
        chk(!err_timeout_o && !err_underflow_o, "R9", "errors cleared by start",
            64'({err_timeout_o, err_underflow_o}), 64'(0));
        if (pulse_again) begin
            // R1: a start during a search is ignored.
            repeat (4) @(negedge clk);
            base_dly_i = ~base;
            start_i    = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (res_q.size() != 0) @(negedge clk);
        @(negedge clk);
        chk(smp_q.size() == 0, "R6", "no samples left over",
            64'(smp_q.size()), 64'(0));
    endtask

    initial begin : main
        for (int l = 0; l < NL; l++) set_lane(l, 128, 64, 0, 0);
        repeat (3) @(negedge clk);
        // R9: reset state.
        chk(dly_o == '0, "R9", "reset delays", 64'(dly_o), 64'(0));
        chk({smp_req_o, pre_req_o, done_o, busy_o} == 4'b0, "R9", "reset controls",
            64'({smp_req_o, pre_req_o, done_o, busy_o}), 64'(0));
        chk(!err_timeout_o && !err_underflow_o, "R9", "reset errors",
            64'({err_timeout_o, err_underflow_o}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(dly_o == '0 && !busy_o, "R9", "idle after reset release",
            64'(dly_o), 64'(0));

        // Patterns 000, 001, 011, 111 (R4) with a restart pulse mid-run (R1).
        set_lane(0, 128, 64, 28, 0);
        set_lane(1, 128, 64, 48, 0);
        set_lane(2, 128, 64, 78, 0);
        set_lane(3, 128, 64, 98, 0);
        run_case(mk_base(100), 0, 1'b1);

        // Patterns 100, 101, 010, 110 (R4), slow sampler (R2).
        set_lane(0, 128, 64, 10, 0);
        set_lane(1, 60, 20, 10, 0);
        set_lane(2, 60, 40, 50, 0);
        set_lane(3, 128, 64, 108, 0);
        run_case(mk_base(100), 2, 1'b0);

        // R8: backward lane at zero samples high while others want to move.
        set_lane(0, 128, 64, 0, 1);
        set_lane(1, 128, 64, 0, 2);
        set_lane(2, 128, 64, 0, 0);
        set_lane(3, 128, 64, 0, 0);
        run_case(mk_base(0), 1, 1'b0);
        repeat (3) @(negedge clk);
        chk(err_underflow_o == 1'b1, "R9", "underflow flag held",
            64'(err_underflow_o), 64'(1));

        // R7: lane 0 needs LIM moves, so the LIM-th sample still moves it.
        set_lane(0, 256, 128, 92, 0);
        set_lane(1, 256, 128, 93, 0);
        set_lane(2, 256, 128, 156, 0);
        set_lane(3, 256, 128, 156, 0);
        run_case(mk_base(200), 1, 1'b0);
        repeat (3) @(negedge clk);
        chk(err_timeout_o == 1'b1, "R9", "timeout flag held",
            64'(err_timeout_o), 64'(1));

        // R6 versus R7: the slowest lane settles exactly on the LIM-th sample.
        set_lane(0, 256, 128, 93, 0);
        run_case(mk_base(200), 0, 1'b0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule